// File: doc/BRIEF.md
# I2C Controller Command and Transmit-Buffer Register

This block holds the software-visible command state of an I2C master/slave controller. Software reaches it through a small register bus with an address, a write strobe, write data and combinational read data. The block passes the enable, stop-request and nak-request bits to the bus engine. The bus engine returns completion events: stop sent, NAK sent, slave transaction active, and transmit byte loaded into the shift register.

The stop and nak request bits are one-way from the software side. A write of 1 sets them, and a write of 0 has no effect. Only hardware clears them: when the operation completes, when the controller is disabled, or (for the stop request) when slave activity is reported. The block also holds the transmit data-holding register and its empty flag. A flush command empties both in a single write. The flush bit is never stored.

The block raises a registered interrupt request while the transmit data register is empty and both the transmit interrupt enable and the controller enable are set. An asynchronous active-low reset is synchronised inside the block. Its release takes effect on the third rising clock edge after rst_n goes high.

Top module: `i2c_cmd_regs`

## Requirements
- R1: After reset the enable, TXI, stop and nak bits are 0, the data register is 0, the empty flag (tdre) is 1 and the interrupt output is 0.
- R2: A write to address 0 with bit 2 = 1 sets the stop request when the enable bit (bit 0) is 1 after that write. A later write with bit 2 = 0 leaves the stop request set.
- R3: The stop request clears on the clock edge that samples ev_stop_done_i = 1 or ev_slave_busy_i = 1.
- R4: A write to address 0 with bit 3 = 1 sets the nak request, and a write with bit 3 = 0 does not clear it. The nak request clears on the clock edge that samples ev_nak_done_i = 1.
- R5: Both requests clear on any edge where the enable bit is 0 after that edge. A set that is written together with enable = 0 is dropped.
- R6: When a completion event and a software set of the same request arrive in the same cycle, the request ends up 0.
- R7: A write to address 0 with bit 4 = 1 sets the data register to 0 and tdre to 1. Bit 4 always reads back as 0.
- R8: A write to address 1 stores the write data in the data register and clears tdre. ev_load_i = 1 sets tdre. When a data write and ev_load_i fall in the same cycle, tdre ends up 0.
- R9: TXI (address 0, bit 1) is read/write. txe_irq_o equals (TXI AND tdre AND enable) as they stood before the previous clock edge, so it lags state by one clock.
- R10: A read of address 0 returns enable in bit 0, TXI in bit 1, stop in bit 2, nak in bit 3 and tdre in bit 7, with all other bits 0. A read of address 1 returns the data register. Other addresses read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr |
| ev_stop_done_i | input | 1 | Engine has sent the STOP condition |
| ev_nak_done_i | input | 1 | Engine has sent the NAK |
| ev_slave_busy_i | input | 1 | A slave-mode transaction is active |
| ev_load_i | input | 1 | Engine took the data byte into its shift register |
| en_o | output | 1 | Controller enable |
| stop_req_o | output | 1 | Stop request to the engine |
| nak_req_o | output | 1 | Nak request to the engine |
| tdre_o | output | 1 | Transmit data register empty |
| data_o | output | DW | Transmit data-holding register |
| txe_irq_o | output | 1 | Registered data-empty interrupt request |

## Verification
The hardest case to reach is a software set that collides with a hardware clear in one cycle. It can come from a completion event, from slave activity, or from a write that drops the enable bit. From the ports this needs the write strobe and the event inputs raised on the same edge. The bench builds these cases as directed steps, and it also runs a long stretch of random writes and events. During that stretch a behavioural model checks every output and the read data once per clock.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int B_EN    = 0;
  localparam int B_TXI   = 1;
  localparam int B_STOP  = 2;
  localparam int B_NAK   = 3;
  localparam int B_FLUSH = 4;
  localparam int B_TDRE  = 7;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_DATA = 1;
  localparam int CMD_STOP = 0;
  localparam int CMD_NAK  = 1;
  localparam int NCMD     = 2;
endpackage

// File: rtl/i2c_cmd_rstsync.sv
module i2c_cmd_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign rst_no = sr_q[STAGES-1];
endmodule

// File: rtl/i2c_cmd_bit.sv
module i2c_cmd_bit (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i)      q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end

  // R2 / R4: software cannot clear a set request
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_i && !clr_i) |=> q_o);
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_i |=> !q_o);
endmodule

// File: rtl/i2c_cmd_txbuf.sv
module i2c_cmd_txbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          flush_i,
  input  logic          load_i,
  output logic [DW-1:0] data_o,
  output logic          tdre_o
);
  logic          data_en;
  logic [DW-1:0] data_d;
  logic          tdre_d;

  always_comb begin
    data_en = flush_i | wr_i;
    data_d  = flush_i ? '0 : wdata_i;
    tdre_d  = tdre_o;
    if (flush_i)     tdre_d = 1'b1;
    else if (wr_i)   tdre_d = 1'b0;
    else if (load_i) tdre_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (data_en) data_o <= data_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) tdre_o <= 1'b1;
    else         tdre_o <= tdre_d;
  end

  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_i |=> (tdre_o && data_o == '0));
  p_write_fills_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && !flush_i) |=> (!tdre_o && data_o == $past(wdata_i)));
  p_load_empty_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_i && !wr_i) |=> tdre_o);
endmodule

// File: rtl/i2c_cmd_irq.sv
module i2c_cmd_irq (
  input  logic clk,
  input  logic rst_ni,
  input  logic en_i,
  input  logic txi_i,
  input  logic tdre_i,
  output logic irq_o
);
  logic irq_d;

  always_comb irq_d = en_i & txi_i & tdre_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && txi_i && tdre_i) |=> irq_o);
  p_irq_full_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tdre_i || !en_i) |=> !irq_o);
endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
  import i2c_cmd_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ev_stop_done_i,
  input  logic          ev_nak_done_i,
  input  logic          ev_slave_busy_i,
  input  logic          ev_load_i,
  output logic          en_o,
  output logic          stop_req_o,
  output logic          nak_req_o,
  output logic          tdre_o,
  output logic [DW-1:0] data_o,
  output logic          txe_irq_o
);
  logic rst_sn;
  logic sel_ctrl, sel_data, wr_ctrl, wr_data;
  logic en_q, en_d, txi_q, txi_d;
  logic [NCMD-1:0] cmd_set, cmd_clr, cmd_q;
  logic [DW-1:0] ctrl_rd;

  i2c_cmd_rstsync #(.STAGES(2)) u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_sn));

  always_comb begin
    sel_ctrl = (addr == AW'(ADDR_CTRL));
    sel_data = (addr == AW'(ADDR_DATA));
    wr_ctrl  = wr_en & sel_ctrl;
    wr_data  = wr_en & sel_data;
    en_d     = wr_ctrl ? wdata[B_EN]  : en_q;
    txi_d    = wr_ctrl ? wdata[B_TXI] : txi_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q  <= 1'b0;
      txi_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= en_d;
      txi_q <= txi_d;
    end
  end

  always_comb begin
    cmd_set[CMD_STOP] = wr_ctrl & wdata[B_STOP];
    cmd_set[CMD_NAK]  = wr_ctrl & wdata[B_NAK];
    cmd_clr[CMD_STOP] = ~en_d | ev_stop_done_i | ev_slave_busy_i;
    cmd_clr[CMD_NAK]  = ~en_d | ev_nak_done_i;
  end

  for (genvar i = 0; i < NCMD; i++) begin : g_cmd
    i2c_cmd_bit u_bit (
      .clk(clk), .rst_ni(rst_sn),
      .set_i(cmd_set[i]), .clr_i(cmd_clr[i]), .q_o(cmd_q[i])
    );
  end

  i2c_cmd_txbuf #(.DW(DW)) u_buf (
    .clk(clk), .rst_ni(rst_sn),
    .wr_i(wr_data), .wdata_i(wdata),
    .flush_i(wr_ctrl & wdata[B_FLUSH]), .load_i(ev_load_i),
    .data_o(data_o), .tdre_o(tdre_o)
  );

  i2c_cmd_irq u_irq (
    .clk(clk), .rst_ni(rst_sn),
    .en_i(en_q), .txi_i(txi_q), .tdre_i(tdre_o), .irq_o(txe_irq_o)
  );

  always_comb begin
    ctrl_rd         = '0;
    ctrl_rd[B_EN]   = en_q;
    ctrl_rd[B_TXI]  = txi_q;
    ctrl_rd[B_STOP] = cmd_q[CMD_STOP];
    ctrl_rd[B_NAK]  = cmd_q[CMD_NAK];
    ctrl_rd[B_TDRE] = tdre_o;
    if (sel_ctrl)      rdata = ctrl_rd;
    else if (sel_data) rdata = data_o;
    else               rdata = '0;
  end

  assign en_o       = en_q;
  assign stop_req_o = cmd_q[CMD_STOP];
  assign nak_req_o  = cmd_q[CMD_NAK];

  p_cmd_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (stop_req_o || nak_req_o) |-> en_o);
  p_slave_drop_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    ev_slave_busy_i |=> !stop_req_o);
  p_flush_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    sel_ctrl |-> (rdata[B_FLUSH] == 1'b0));
endmodule

// File: tb/sim_i2c_cmd_regs.sv
`timescale 1ns/100ps
module sim_i2c_cmd_regs;
  localparam int AW = 2;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ev_stop = 1'b0, ev_nak = 1'b0, ev_slave = 1'b0, ev_load = 1'b0;
  logic [DW-1:0] rdata, data_o;
  logic en_o, stop_o, nak_o, tdre_o, irq_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_cmd_regs #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_stop_done_i(ev_stop), .ev_nak_done_i(ev_nak),
    .ev_slave_busy_i(ev_slave), .ev_load_i(ev_load), .en_o(en_o),
    .stop_req_o(stop_o), .nak_req_o(nak_o), .tdre_o(tdre_o),
    .data_o(data_o), .txe_irq_o(irq_o)
  );

  // behavioural reference model
  bit m_en = 0, m_txi = 0, m_stop = 0, m_nak = 0, m_tdre = 1, m_irq = 0;
  int m_data = 0;
  int rcnt = 0;

  always @(posedge clk) begin
    bit wc, wd, nen;
    wc = wr_en && addr == 0;
    wd = wr_en && addr == 1;
    if (!rst_n || rcnt < 2) begin
      if (rst_n) rcnt++; else rcnt = 0;
      m_en = 0; m_txi = 0; m_stop = 0; m_nak = 0; m_tdre = 1; m_irq = 0; m_data = 0;
    end else begin
      m_irq = m_en && m_txi && m_tdre;
      nen = wc ? wdata[0] : m_en;
      if (!nen || ev_stop || ev_slave) m_stop = 0;
      else if (wc && wdata[2])          m_stop = 1;
      if (!nen || ev_nak)               m_nak = 0;
      else if (wc && wdata[3])          m_nak = 1;
      if (wc && wdata[4])   begin m_data = 0; m_tdre = 1; end
      else if (wd)          begin m_data = wdata; m_tdre = 0; end
      else if (ev_load)     m_tdre = 1;
      if (wc) begin m_en = wdata[0]; m_txi = wdata[1]; end
    end
  end

  function automatic int model_rd();
    if (addr == 0) return {m_tdre, 3'b000, m_nak, m_stop, m_txi, m_en};
    if (addr == 1) return m_data;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 en_o", en_o, m_en);
      check("R2 stop_req_o", stop_o, m_stop);
      check("R4 nak_req_o", nak_o, m_nak);
      check("R8 tdre_o", tdre_o, m_tdre);
      check("R8 data_o", data_o, m_data);
      check("R9 txe_irq_o", irq_o, m_irq);
      check("R10 rdata", rdata, model_rd());
    end
  end

  task automatic step();
    @(posedge clk); #1;
    wr_en = 0; ev_stop = 0; ev_nak = 0; ev_slave = 0; ev_load = 0;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; addr = a[AW-1:0]; wdata = d[DW-1:0];
    step();
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) step();
    // R1 reset state
    check("R1 en", en_o, 0);   check("R1 stop", stop_o, 0);
    check("R1 nak", nak_o, 0); check("R1 tdre", tdre_o, 1);
    check("R1 data", data_o, 0); check("R1 irq", irq_o, 0);
    // R9 irq lags by one clock
    wr(0, 8'h03);
    check("R9 irq before", irq_o, 0);
    step();
    check("R9 irq after", irq_o, 1);
    // R8 data write
    wr(1, 8'hA5);
    check("R8 tdre cleared", tdre_o, 0); check("R8 data", data_o, 8'hA5);
    step();
    check("R9 irq drops", irq_o, 0);
    ev_load = 1; step();
    check("R8 load sets tdre", tdre_o, 1);
    // R2 sticky stop, R3 completion
    wr(0, 8'h07); check("R2 stop set", stop_o, 1);
    wr(0, 8'h03); check("R2 stop sticky", stop_o, 1);
    ev_stop = 1; step(); check("R3 stop done clears", stop_o, 0);
    wr(0, 8'h07); ev_slave = 1; step(); check("R3 slave clears", stop_o, 0);
    // R4 nak
    wr(0, 8'h0B); check("R4 nak set", nak_o, 1);
    wr(0, 8'h03); check("R4 nak sticky", nak_o, 1);
    ev_nak = 1; step(); check("R4 nak done clears", nak_o, 0);
    // R5 disable clears
    wr(0, 8'h0F);
    wr(0, 8'h00); check("R5 stop off", stop_o, 0); check("R5 nak off", nak_o, 0);
    wr(0, 8'h0C); check("R5 set with en=0 dropped", stop_o | nak_o, 0);
    // R6 collision
    wr_en = 1; addr = 0; wdata = 8'h0D; ev_stop = 1; ev_nak = 1; step();
    check("R6 stop collision", stop_o, 0); check("R6 nak collision", nak_o, 0);
    // R7 flush
    wr(1, 8'h5A);
    wr(0, 8'h11);
    check("R7 data zero", data_o, 0); check("R7 tdre set", tdre_o, 1);
    check("R7 flush reads 0", rdata[4], 0);
    // R8 write and load same cycle
    wr_en = 1; addr = 1; wdata = 8'h3C; ev_load = 1; step();
    check("R8 write beats load", tdre_o, 0);
    // R10 readback
    addr = 1; #1 check("R10 data read", rdata, 8'h3C);
    addr = 0; #1 check("R10 ctrl read", rdata, 8'h01);
    wr(2, 8'hFF); addr = 2; #1 check("R10 unmapped", rdata, 0);
    addr = 0; #1 check("R10 unmapped write ignored", rdata, 8'h01);
    // random phase with model comparison
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom % 3) == 0;
      addr = AW'($urandom % 3);
      wdata = DW'($urandom | ((($urandom % 4) != 0) ? 1 : 0));
      ev_stop = ($urandom % 7) == 0;
      ev_nak = ($urandom % 7) == 0;
      ev_slave = ($urandom % 11) == 0;
      ev_load = ($urandom % 5) == 0;
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule